// File: doc/BRIEF.md
# Automatic Remote Alarm Transmitter

This block sits on the transmit side of an E1 framer and decides, once per clock, whether the far end should be told about local receive trouble. Two request bits are produced. The remote alarm request becomes bit 3 of the transmitted NFAS word. The multiframe alarm request, the Y bit, becomes bit 6 of the multiframe alignment word. Each request follows its own loss-of-alignment flag, and only while its active-low automatic enable is held at 0.

The block also qualifies the receive signal over time. It counts millisecond ticks while the normal/abnormal indication holds one level. Its bad-signal status rises after 100 ticks of abnormal input, and its good-signal status rises after 10 ticks of normal input. Any change of the indication restarts the count. Each status bit also gives a one-cycle pulse when it rises, for an interrupt controller to pick up.

Top module: `remote_alarm_tx`

## Requirements
- R1: With `rai_auto_n_i` = 0 and `frm_lost_i` = 1 sampled at a clock edge, `rai_req_o` is 1 after that edge.
- R2: With `frm_lost_i` = 0 sampled at an edge, `rai_req_o` is 0 after that edge.
- R3: With `rai_auto_n_i` = 1 sampled at an edge, `rai_req_o` is 0 after that edge, whatever `frm_lost_i` is.
- R4: With `y_auto_n_i` = 0 and `mfrm_lost_i` = 1 sampled at an edge, `y_req_o` is 1 after that edge.
- R5: With `mfrm_lost_i` = 0 sampled at an edge, `y_req_o` is 0 after that edge.
- R6: With `y_auto_n_i` = 1 sampled at an edge, `y_req_o` is 0 after that edge, whatever `mfrm_lost_i` is.
- R7: `sig_ok_i` = 0 means abnormal. `bad_tmr_o` rises at the edge where the 100th tick of a run of abnormal input is counted. A tick is counted at an edge where `ms_tick_i` = 1 and `sig_ok_i` equals its value at the previous edge.
- R8: `bad_tmr_o` is 0 after any edge at which `sig_ok_i` = 1.
- R9: `good_tmr_o` rises at the edge where the 10th tick of a run of normal input (`sig_ok_i` = 1) is counted. Cycles with `ms_tick_i` = 0 add nothing to the count.
- R10: `good_tmr_o` is 0 after any edge at which `sig_ok_i` = 0.
- R11: Any change of `sig_ok_i` clears the tick count. A run that is interrupted starts again from zero.
- R12: A count saturates at its threshold. Once a status bit is high it stays high under further ticks for as long as its level holds.
- R13: `bad_evt_o` and `good_evt_o` are high for exactly the one cycle in which the matching status bit has just risen.
- R14: After reset all outputs are 0. `bad_tmr_o` and `good_tmr_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_lost_i | input | 1 | Basic frame alignment lost |
| mfrm_lost_i | input | 1 | Signalling multiframe alignment lost |
| sig_ok_i | input | 1 | 1 = normal receive signal, 0 = abnormal |
| rai_auto_n_i | input | 1 | Automatic remote alarm enable, active low |
| y_auto_n_i | input | 1 | Automatic Y-bit alarm enable, active low |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| rai_req_o | output | 1 | Remote alarm transmit request (NFAS bit 3) |
| y_req_o | output | 1 | Y-bit transmit request (multiframe word bit 6) |
| bad_tmr_o | output | 1 | Abnormal signal held for at least 100 ticks |
| good_tmr_o | output | 1 | Normal signal held for at least 10 ticks |
| bad_evt_o | output | 1 | One-cycle pulse on the rise of `bad_tmr_o` |
| good_evt_o | output | 1 | One-cycle pulse on the rise of `good_tmr_o` |

## Verification
The bench checks the timer thresholds to the exact edge: one edge early must still read low, and the threshold edge must read high. A design with an off-by-one in its count, or one that also counted the tick sampled at the level change, would fail that pair of checks. An abnormal run is broken by a single normal cycle at a point where the old count would already have passed 100 ticks, so a counter that did not restart would raise the bad status too soon. Long tick runs after the threshold would catch a counter that wraps and drops the status. For the request paths, the enable is set to 1 while alignment is lost, and the requests are watched as alignment returns, so a design with inverted enable polarity or a sticky request would show up.

// File: rtl/ralm_pkg.sv
package ralm_pkg;

    // Index of each alarm request lane in the gate array
    localparam int unsigned LANE_RAI = 0;
    localparam int unsigned LANE_Y   = 1;
    localparam int unsigned N_LANES  = 2;

    // One alarm request lane: loss flag plus active-low automatic enable
    typedef struct packed {
        logic lost;
        logic auto_n;
    } lane_in_t;

    // Persistence timer result
    typedef struct packed {
        logic status;
        logic rise;
    } tmr_out_t;

    // Width of a counter that must reach th without wrapping
    function automatic int unsigned cnt_width(input int unsigned th);
        return (th < 2) ? 1 : $clog2(th + 1);
    endfunction

    // Request is wanted when the automatic enable is low and alignment is lost
    function automatic logic lane_wants(input lane_in_t l);
        return l.lost & ~l.auto_n;
    endfunction

endpackage

// File: rtl/ralm_req_gate.sv
module ralm_req_gate
    import ralm_pkg::*;
#(
    parameter int unsigned N = N_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_in_t [N-1:0]  lane_i,
    output logic     [N-1:0]  req_o
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic req_q;
        always_ff @(posedge clk) begin
            if (rst) req_q <= 1'b0;
            else     req_q <= lane_wants(lane_i[g]);
        end
        assign req_o[g] = req_q;
    end

endmodule

// File: rtl/ralm_persist_tmr.sv
module ralm_persist_tmr
    import ralm_pkg::*;
#(
    parameter int unsigned THRESH = 100,
    parameter bit          LEVEL  = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     level_i,
    input  logic     prev_i,
    input  logic     tick_i,
    output tmr_out_t out_o
);

    localparam int unsigned CW = cnt_width(THRESH);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          status_q, rise_q, status_d;
    logic          in_level, changed;

    assign in_level = (level_i == LEVEL);
    assign changed  = (level_i != prev_i);

    always_comb begin
        if (!in_level || changed)          cnt_d = '0;
        else if (tick_i && cnt_q < LIMIT)  cnt_d = cnt_q + 1'b1;
        else                               cnt_d = cnt_q;
        status_d = (cnt_d == LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            status_q <= 1'b0;
            rise_q   <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            status_q <= status_d;
            rise_q   <= status_d & ~status_q;
        end
    end

    assign out_o.status = status_q;
    assign out_o.rise   = rise_q;

endmodule

// File: rtl/remote_alarm_tx.sv
module remote_alarm_tx
    import ralm_pkg::*;
#(
    parameter int unsigned BAD_TICKS  = 100,
    parameter int unsigned GOOD_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic frm_lost_i,
    input  logic mfrm_lost_i,
    input  logic sig_ok_i,
    input  logic rai_auto_n_i,
    input  logic y_auto_n_i,
    input  logic ms_tick_i,
    output logic rai_req_o,
    output logic y_req_o,
    output logic bad_tmr_o,
    output logic good_tmr_o,
    output logic bad_evt_o,
    output logic good_evt_o
);

    lane_in_t [N_LANES-1:0] lanes;
    logic     [N_LANES-1:0] reqs;
    logic                   sig_prev_q;
    tmr_out_t               bad_t, good_t;

    assign lanes[LANE_RAI] = '{lost: frm_lost_i,  auto_n: rai_auto_n_i};
    assign lanes[LANE_Y]   = '{lost: mfrm_lost_i, auto_n: y_auto_n_i};

    ralm_req_gate #(.N(N_LANES)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .lane_i (lanes),
        .req_o  (reqs)
    );

    // Shared history of the signal indication for change detection
    always_ff @(posedge clk) begin
        if (rst) sig_prev_q <= 1'b0;
        else     sig_prev_q <= sig_ok_i;
    end

    ralm_persist_tmr #(.THRESH(BAD_TICKS), .LEVEL(1'b0)) u_bad (
        .clk     (clk),
        .rst     (rst),
        .level_i (sig_ok_i),
        .prev_i  (sig_prev_q),
        .tick_i  (ms_tick_i),
        .out_o   (bad_t)
    );

    ralm_persist_tmr #(.THRESH(GOOD_TICKS), .LEVEL(1'b1)) u_good (
        .clk     (clk),
        .rst     (rst),
        .level_i (sig_ok_i),
        .prev_i  (sig_prev_q),
        .tick_i  (ms_tick_i),
        .out_o   (good_t)
    );

    assign rai_req_o  = reqs[LANE_RAI];
    assign y_req_o    = reqs[LANE_Y];
    assign bad_tmr_o  = bad_t.status;
    assign bad_evt_o  = bad_t.rise;
    assign good_tmr_o = good_t.status;
    assign good_evt_o = good_t.rise;

endmodule

// File: rtl/ralm_chk.sv
module ralm_chk (
    input logic clk,
    input logic rst,
    input logic frm_lost_i,
    input logic mfrm_lost_i,
    input logic sig_ok_i,
    input logic rai_auto_n_i,
    input logic y_auto_n_i,
    input logic rai_req_o,
    input logic y_req_o,
    input logic bad_tmr_o,
    input logic good_tmr_o,
    input logic bad_evt_o,
    input logic good_evt_o
);

    a_r1_rai_set: assert property (@(posedge clk) disable iff (rst)
        (!rai_auto_n_i && frm_lost_i) |=> rai_req_o);
    a_r2_rai_clear: assert property (@(posedge clk) disable iff (rst)
        !frm_lost_i |=> !rai_req_o);
    a_r3_rai_off: assert property (@(posedge clk) disable iff (rst)
        rai_auto_n_i |=> !rai_req_o);
    a_r4_y_set: assert property (@(posedge clk) disable iff (rst)
        (!y_auto_n_i && mfrm_lost_i) |=> y_req_o);
    a_r5_y_clear: assert property (@(posedge clk) disable iff (rst)
        !mfrm_lost_i |=> !y_req_o);
    a_r6_y_off: assert property (@(posedge clk) disable iff (rst)
        y_auto_n_i |=> !y_req_o);
    a_r8_bad_low: assert property (@(posedge clk) disable iff (rst)
        sig_ok_i |=> !bad_tmr_o);
    a_r10_good_low: assert property (@(posedge clk) disable iff (rst)
        !sig_ok_i |=> !good_tmr_o);
    a_r13_bad_evt: assert property (@(posedge clk) disable iff (rst)
        bad_evt_o |-> bad_tmr_o);
    a_r13_good_evt: assert property (@(posedge clk) disable iff (rst)
        good_evt_o |-> good_tmr_o);
    a_r13_bad_single: assert property (@(posedge clk) disable iff (rst)
        bad_evt_o |=> !bad_evt_o);
    a_r14_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bad_tmr_o, good_tmr_o}));

endmodule

bind remote_alarm_tx ralm_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .frm_lost_i   (frm_lost_i),
    .mfrm_lost_i  (mfrm_lost_i),
    .sig_ok_i     (sig_ok_i),
    .rai_auto_n_i (rai_auto_n_i),
    .y_auto_n_i   (y_auto_n_i),
    .rai_req_o    (rai_req_o),
    .y_req_o      (y_req_o),
    .bad_tmr_o    (bad_tmr_o),
    .good_tmr_o   (good_tmr_o),
    .bad_evt_o    (bad_evt_o),
    .good_evt_o   (good_evt_o)
);

// File: tb/remote_alarm_tx_tb.sv
module remote_alarm_tx_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frm_lost_i = 1'b0, mfrm_lost_i = 1'b0, sig_ok_i = 1'b1;
    logic rai_auto_n_i = 1'b1, y_auto_n_i = 1'b1, ms_tick_i = 1'b0;
    logic rai_req_o, y_req_o, bad_tmr_o, good_tmr_o, bad_evt_o, good_evt_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    remote_alarm_tx u_dut (
        .clk(clk), .rst(rst),
        .frm_lost_i(frm_lost_i), .mfrm_lost_i(mfrm_lost_i), .sig_ok_i(sig_ok_i),
        .rai_auto_n_i(rai_auto_n_i), .y_auto_n_i(y_auto_n_i), .ms_tick_i(ms_tick_i),
        .rai_req_o(rai_req_o), .y_req_o(y_req_o),
        .bad_tmr_o(bad_tmr_o), .good_tmr_o(good_tmr_o),
        .bad_evt_o(bad_evt_o), .good_evt_o(good_evt_o)
    );

    // Vector: {frm_lost, mfrm_lost, rai_auto_n, y_auto_n, exp_rai, exp_y}
    localparam int NV = 10;
    localparam logic [5:0] VEC [NV] = '{
        6'b11_00_11,  // R1 R4 both requested
        6'b01_00_01,  // R2 RAI stops on regain
        6'b00_00_00,  // R5 Y stops on regain
        6'b11_10_01,  // R3 RAI disabled
        6'b11_01_10,  // R6 Y disabled
        6'b11_11_00,  // R3 R6 both disabled
        6'b10_00_10,  // R1 alone
        6'b01_01_00,  // R6 Y disabled while lost
        6'b01_00_01,  // R4 alone
        6'b00_11_00   // R2 R5 idle
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // One clock: inputs already set at the falling edge, sample 1 ns after rise
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_sig(input logic v);
        @(negedge clk);
        sig_ok_i = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R14 reset rai", rai_req_o, 1'b0);
        chk("R14 reset y", y_req_o, 1'b0);
        chk("R14 reset bad", bad_tmr_o, 1'b0);
        chk("R14 reset good", good_tmr_o, 1'b0);
        chk("R14 reset evt", bad_evt_o | good_evt_o, 1'b0);

        // Request table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {frm_lost_i, mfrm_lost_i, rai_auto_n_i, y_auto_n_i} = VEC[v][5:2];
            step(1);
            chk("R1-6 vec rai", rai_req_o, VEC[v][1]);
            chk("R1-6 vec y", y_req_o, VEC[v][0]);
        end

        // Good timer with ticks held off: no progress (R9)
        @(negedge clk);
        ms_tick_i = 1'b0;
        sig_ok_i  = 1'b1;
        step(30);
        chk("R9 no ticks good", good_tmr_o, 1'b0);

        // Normal run with ticks: change edge, then 10 counted ticks (R9)
        set_sig(1'b0);
        step(1);
        set_sig(1'b1);
        ms_tick_i = 1'b1;
        step(10);
        chk("R9 good early", good_tmr_o, 1'b0);
        step(1);
        chk("R9 good at 10", good_tmr_o, 1'b1);
        chk("R13 good evt", good_evt_o, 1'b1);
        step(1);
        chk("R13 good evt single", good_evt_o, 1'b0);
        chk("R12 good holds", good_tmr_o, 1'b1);

        // Abnormal run: good drops, bad at 100 ticks (R10 R7)
        set_sig(1'b0);
        step(1);
        chk("R10 good low", good_tmr_o, 1'b0);
        step(99);
        chk("R7 bad early", bad_tmr_o, 1'b0);
        step(1);
        chk("R7 bad at 100", bad_tmr_o, 1'b1);
        chk("R13 bad evt", bad_evt_o, 1'b1);
        chk("R14 exclusive", good_tmr_o, 1'b0);
        step(1);
        chk("R13 bad evt single", bad_evt_o, 1'b0);
        step(300);
        chk("R12 bad saturates", bad_tmr_o, 1'b1);
        chk("R12 no new evt", bad_evt_o, 1'b0);

        // Normal again: bad drops (R8)
        set_sig(1'b1);
        step(1);
        chk("R8 bad low", bad_tmr_o, 1'b0);
        step(20);

        // Interrupted abnormal run restarts (R11)
        set_sig(1'b0);
        step(50);
        set_sig(1'b1);
        step(1);
        set_sig(1'b0);
        step(60);
        chk("R11 restart no early bad", bad_tmr_o, 1'b0);
        step(40);
        chk("R11 restart at 99", bad_tmr_o, 1'b0);
        step(1);
        chk("R11 restart at 100", bad_tmr_o, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule